// File: doc/BRIEF.md
# Stochastic Binary Spike-Timing Learning Core

This block is one learning core of a spiking network. A row of input spike lines feeds a bank of one-bit synapses. Each input line drives `FANOUT` adjacent synapses. A single leaky integrate-and-fire neuron sums the contributions of the conducting synapses whose inputs spike in a clock cycle, subtracts a programmable leak and emits an output spike when its potential reaches a programmable threshold. After each output spike the neuron stays silent for a programmable number of cycles.

Learning happens only when the neuron fires. Each input keeps a down-counting recency timer. At the firing edge, every synapse whose input was active inside the recency window may turn on, and every other synapse may turn off. The outcome for each synapse is a random draw: a per-synapse potentiation enable and a per-synapse depression enable come from an external random source. A two-bit learning control switches potentiation and depression on or off independently of each other.

The default build has 64 inputs with 3 synapses each, 192 synapses in total. All weights reset to a parameter value, which is all ones by default.

Top module: `stdp_core`

## Requirements
- R1: While reset is asserted (synchronous, active low), the weights take the value of `W_RESET` (default all ones), `membrane` is 0, `out_spike` is 0 and all recency timers are 0.
- R2: At a firing edge, input i counts as recent if it spikes in that same cycle or in any of the preceding `win_len` cycles. Its timer loads `win_len` when the input spikes and otherwise counts down to 0; a nonzero timer means recent.
- R3: The weight vector changes only at an edge where the neuron fires. At every other edge it holds, whatever the enables and `learn_ctl` are.
- R4: At a firing edge, synapse j (fed by input j/FANOUT) becomes 1 if its input is recent, `ltp_en[j]` is 1 and `learn_ctl[0]` is 1. A recent synapse is never cleared.
- R5: At a firing edge, synapse j becomes 0 if its input is not recent, `ltd_en[j]` is 1 and `learn_ctl[1]` is 1. A synapse that is not recent is never set.
- R6: Outside refractory, the next potential is `membrane + A - leak`, floored at 0 and capped at the largest `POT_W`-bit value. A is the number of synapses with weight 1 whose input spikes in that cycle.
- R7: When the next potential reaches `threshold` (greater than or equal to), `out_spike` is 1 for exactly the one cycle after that edge, and `membrane` is 0 at the same time.
- R8: For the `refr_len` edges after a firing edge, input spikes are ignored, `membrane` stays 0 and no spike is emitted. If `refr_len` is 0, integration resumes at the next edge.
- R9: Weights written at a firing edge are the ones used for integration from the next edge onward. Integration in the firing cycle uses the old weights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_spike | input | N_IN | Input spike lines, one per input |
| ltp_en | input | N_IN*FANOUT | Random per-synapse potentiation enables |
| ltd_en | input | N_IN*FANOUT | Random per-synapse depression enables |
| learn_ctl | input | 2 | Bit 0 allows potentiation, bit 1 allows depression |
| win_len | input | WIN_W | Recency window length in cycles |
| threshold | input | POT_W | Firing threshold |
| leak | input | POT_W | Leak subtracted every cycle |
| refr_len | input | REF_W | Refractory length in cycles |
| weights | output | N_IN*FANOUT | Current synapse bits |
| membrane | output | POT_W | Current membrane potential |
| out_spike | output | 1 | Output spike, one cycle wide |

## Verification
Two functions can fall in the same cycle. First, an input spike can push the neuron over threshold while that same spike is also what makes its input recent for the weight update. Second, the firing edge updates the weights while integration in that cycle still reads the old weights. The bench provokes both: in one case a single input's spike is the one that causes the fire, and in another the update is followed at once by a spike on a newly potentiated synapse. A cycle-level reference model of the requirements is compared against the weights, potential and spike after every edge. The recency window is probed at its exact boundary: one input spikes exactly `win_len` cycles before the fire and another spikes one cycle earlier than that.

// File: rtl/stdp_pkg.sv
// Package: shared definitions for the stochastic binary learning core.
// Assumes learning control bit positions are fixed by the port contract.
package stdp_pkg;
    // Position of the potentiation allow bit in learn_ctl.
    localparam int LTP_BIT = 0;
    // Position of the depression allow bit in learn_ctl.
    localparam int LTD_BIT = 1;

    // Decoded view of the two-bit learning control.
    typedef struct packed {
        logic ltd_allow;
        logic ltp_allow;
    } learn_ctl_t;
endpackage

// File: rtl/stdp_recency.sv
// Module: per-input recency timers.
// Each timer loads the window length on a spike and counts down to zero.
// An input is reported recent while its timer is nonzero or while it spikes
// in the current cycle. Assumes win_len is stable except between tests.
module stdp_recency #(
    parameter int N_IN  = 64,
    parameter int WIN_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   in_spike,
    input  logic [WIN_W-1:0]  win_len,
    output logic [N_IN-1:0]   recent
);
    for (genvar i = 0; i < N_IN; i++) begin : g_timer
        logic [WIN_W-1:0] tmr_q;

        // Load on spike, otherwise count down and hold at zero.
        always_ff @(posedge clk) begin
            if (!rst_n)
                tmr_q <= '0;
            else if (in_spike[i])
                tmr_q <= win_len;
            else if (tmr_q != '0)
                tmr_q <= tmr_q - 1'b1;
        end

        assign recent[i] = in_spike[i] | (tmr_q != '0);

        AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            in_spike[i] |=> (tmr_q == $past(win_len)));   // R2
        AST_TIMER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
            (!in_spike[i] && tmr_q == '0) |=> (tmr_q == '0)); // R2
    end
endmodule

// File: rtl/stdp_lif_neuron.sv
// Module: leaky integrate-and-fire neuron with refractory hold.
// The fire decision is combinational from the current potential and the
// active synapse count, so the learning update can share the firing edge.
// Assumes CNT_W <= POT_W so the sum fits in POT_W+1 bits.
module stdp_lif_neuron #(
    parameter int POT_W = 10,
    parameter int CNT_W = 8,
    parameter int REF_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  active_cnt,
    input  logic [POT_W-1:0]  leak,
    input  logic [POT_W-1:0]  threshold,
    input  logic [REF_W-1:0]  refr_len,
    output logic              fire,
    output logic [POT_W-1:0]  membrane,
    output logic              spike_out
);
    localparam int SUM_W = POT_W + 1;

    logic [POT_W-1:0] pot_q;
    logic [REF_W-1:0] ref_q;
    logic             spike_q;
    logic [SUM_W-1:0] sum_c;
    logic [SUM_W-1:0] leaked_c;
    logic [POT_W-1:0] next_pot_c;
    logic             in_refr_c;

    // Add active count, subtract leak with floor at zero, cap at maximum.
    always_comb begin
        sum_c      = {1'b0, pot_q} + SUM_W'(active_cnt);
        leaked_c   = (sum_c > SUM_W'(leak)) ? (sum_c - SUM_W'(leak)) : '0;
        next_pot_c = leaked_c[POT_W] ? '1 : leaked_c[POT_W-1:0];
        in_refr_c  = (ref_q != '0);
        fire       = !in_refr_c && (next_pot_c >= threshold);
    end

    // Potential, refractory counter and spike register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pot_q   <= '0;
            ref_q   <= '0;
            spike_q <= 1'b0;
        end else if (in_refr_c) begin
            pot_q   <= '0;
            ref_q   <= ref_q - 1'b1;
            spike_q <= 1'b0;
        end else if (fire) begin
            pot_q   <= '0;
            ref_q   <= refr_len;
            spike_q <= 1'b1;
        end else begin
            pot_q   <= next_pot_c;
            spike_q <= 1'b0;
        end
    end

    assign membrane  = pot_q;
    assign spike_out = spike_q;

    AST_REFR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_q != '0) |=> (pot_q == '0 && !spike_q));        // R8
    AST_FIRE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (spike_q && pot_q == '0));                  // R7
    AST_SPIKE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        spike_q |=> !spike_q || $past(refr_len) == '0);     // R7
endmodule

// File: rtl/stdp_syn_array.sv
// Module: one-bit synapse bank with stochastic set/clear on output firing.
// Synapse j is fed by input j/FANOUT. Also produces the count of conducting
// synapses whose input spikes this cycle. Assumes enables are already random.
module stdp_syn_array
    import stdp_pkg::*;
#(
    parameter int N_IN   = 64,
    parameter int FANOUT = 3,
    parameter int N_SYN  = N_IN * FANOUT,
    parameter int CNT_W  = 8,
    parameter logic [N_SYN-1:0] W_RESET = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   in_spike,
    input  logic [N_IN-1:0]   recent,
    input  logic [N_SYN-1:0]  ltp_en,
    input  logic [N_SYN-1:0]  ltd_en,
    input  learn_ctl_t        ctl,
    input  logic              fire,
    output logic [N_SYN-1:0]  weights,
    output logic [CNT_W-1:0]  active_cnt
);
    logic [N_SYN-1:0] w_q;
    logic [N_SYN-1:0] rec_syn;
    logic [N_SYN-1:0] hit;

    for (genvar j = 0; j < N_SYN; j++) begin : g_syn
        localparam int SRC = j / FANOUT;

        assign rec_syn[j] = recent[SRC];
        assign hit[j]     = w_q[j] & in_spike[SRC];

        // Gated random set for recent inputs, gated random clear otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n)
                w_q[j] <= W_RESET[j];
            else if (fire) begin
                if (rec_syn[j]) begin
                    if (ltp_en[j] && ctl.ltp_allow)
                        w_q[j] <= 1'b1;
                end else if (ltd_en[j] && ctl.ltd_allow)
                    w_q[j] <= 1'b0;
            end
        end
    end

    // Count conducting synapses whose input spikes this cycle.
    always_comb begin
        active_cnt = '0;
        for (int j = 0; j < N_SYN; j++)
            active_cnt = active_cnt + CNT_W'(hit[j]);
    end

    assign weights = w_q;

    AST_HOLD_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(w_q));                                        // R3
    AST_NO_SET_STALE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ((w_q & ~$past(w_q) & ~$past(rec_syn)) == '0));       // R5
    AST_NO_CLEAR_RECENT: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ((~w_q & $past(w_q) & $past(rec_syn)) == '0));        // R4
endmodule

// File: rtl/stdp_core.sv
// Module: top of the stochastic binary learning core.
// Wires recency timers, synapse bank and output neuron. Learning happens
// on the same edge that registers the output spike. Assumes configuration
// inputs are held steady while spikes are applied.
module stdp_core
    import stdp_pkg::*;
#(
    parameter int N_IN   = 64,
    parameter int FANOUT = 3,
    parameter int WIN_W  = 6,
    parameter int POT_W  = 10,
    parameter int REF_W  = 6,
    parameter logic [N_IN*FANOUT-1:0] W_RESET = '1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_IN-1:0]         in_spike,
    input  logic [N_IN*FANOUT-1:0]  ltp_en,
    input  logic [N_IN*FANOUT-1:0]  ltd_en,
    input  logic [1:0]              learn_ctl,
    input  logic [WIN_W-1:0]        win_len,
    input  logic [POT_W-1:0]        threshold,
    input  logic [POT_W-1:0]        leak,
    input  logic [REF_W-1:0]        refr_len,
    output logic [N_IN*FANOUT-1:0]  weights,
    output logic [POT_W-1:0]        membrane,
    output logic                    out_spike
);
    localparam int N_SYN = N_IN * FANOUT;
    localparam int CNT_W = $clog2(N_SYN + 1);

    logic [N_IN-1:0]  recent;
    logic [CNT_W-1:0] active_cnt;
    logic             fire;
    learn_ctl_t       ctl;

    assign ctl.ltp_allow = learn_ctl[LTP_BIT];
    assign ctl.ltd_allow = learn_ctl[LTD_BIT];

    stdp_recency #(
        .N_IN  (N_IN),
        .WIN_W (WIN_W)
    ) u_recency (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_spike (in_spike),
        .win_len  (win_len),
        .recent   (recent)
    );

    stdp_syn_array #(
        .N_IN    (N_IN),
        .FANOUT  (FANOUT),
        .N_SYN   (N_SYN),
        .CNT_W   (CNT_W),
        .W_RESET (W_RESET)
    ) u_syn (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_spike   (in_spike),
        .recent     (recent),
        .ltp_en     (ltp_en),
        .ltd_en     (ltd_en),
        .ctl        (ctl),
        .fire       (fire),
        .weights    (weights),
        .active_cnt (active_cnt)
    );

    stdp_lif_neuron #(
        .POT_W (POT_W),
        .CNT_W (CNT_W),
        .REF_W (REF_W)
    ) u_neuron (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_cnt (active_cnt),
        .leak       (leak),
        .threshold  (threshold),
        .refr_len   (refr_len),
        .fire       (fire),
        .membrane   (membrane),
        .spike_out  (out_spike)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (weights == W_RESET && membrane == '0 && !out_spike)); // R1
endmodule

// File: tb/stdp_core_tb.sv
// Bench: directed scenarios against a cycle-level reference model.
module stdp_core_tb;
    localparam int N_IN = 4, FANOUT = 2, N_SYN = 8;
    localparam int WIN_W = 4, POT_W = 8, REF_W = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N_IN-1:0]  in_spike = '0;
    logic [N_SYN-1:0] ltp_en = '0, ltd_en = '0;
    logic [1:0]       learn_ctl = '0;
    logic [WIN_W-1:0] win_len = 4'd3;
    logic [POT_W-1:0] threshold = 8'd200, leak = '0;
    logic [REF_W-1:0] refr_len = '0;
    logic [N_SYN-1:0] weights;
    logic [POT_W-1:0] membrane;
    logic             out_spike;

    always #5 clk = ~clk;

    stdp_core #(.N_IN(N_IN), .FANOUT(FANOUT), .WIN_W(WIN_W),
                .POT_W(POT_W), .REF_W(REF_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_spike(in_spike), .ltp_en(ltp_en),
        .ltd_en(ltd_en), .learn_ctl(learn_ctl), .win_len(win_len),
        .threshold(threshold), .leak(leak), .refr_len(refr_len),
        .weights(weights), .membrane(membrane), .out_spike(out_spike));

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // Reference state.
    logic [N_SYN-1:0] m_w;
    int m_pot, m_ref, m_tmr[N_IN];
    bit m_spk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Advance the model by one edge from the currently driven inputs.
    task automatic model_step();
        bit rec[N_IN];
        int act, s, nxt;
        bit fire;
        for (int i = 0; i < N_IN; i++) rec[i] = in_spike[i] || (m_tmr[i] != 0);
        fire = 0;
        if (m_ref != 0) begin
            m_ref--; m_pot = 0;
        end else begin
            act = 0;
            for (int j = 0; j < N_SYN; j++)
                if (m_w[j] && in_spike[j/FANOUT]) act++;
            s = m_pot + act;
            nxt = (s > leak) ? s - leak : 0;
            if (nxt > 255) nxt = 255;
            fire = (nxt >= threshold);
            if (fire) begin
                m_pot = 0; m_ref = refr_len;
                for (int j = 0; j < N_SYN; j++) begin
                    if (rec[j/FANOUT]) begin
                        if (ltp_en[j] && learn_ctl[0]) m_w[j] = 1'b1;
                    end else if (ltd_en[j] && learn_ctl[1]) m_w[j] = 1'b0;
                end
            end else m_pot = nxt;
        end
        m_spk = fire;
        for (int i = 0; i < N_IN; i++)
            m_tmr[i] = in_spike[i] ? int'(win_len) : (m_tmr[i] != 0 ? m_tmr[i] - 1 : 0);
    endtask

    // One edge, then compare all outputs to the model.
    task automatic cycle(input string req);
        model_step();
        @(posedge clk); #1;
        chk(req, "weights", 32'(weights), 32'(m_w));
        chk(req, "membrane", 32'(membrane), 32'(m_pot));
        chk(req, "out_spike", 32'(out_spike), 32'(m_spk));
    endtask

    task automatic idle(input int n, input string req);
        in_spike = '0;
        for (int k = 0; k < n; k++) cycle(req);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "weights", 32'(weights), 32'hFF);
        chk("R1", "membrane", 32'(membrane), 0);
        chk("R1", "out_spike", 32'(out_spike), 0);
        m_w = '1; m_pot = 0; m_ref = 0; m_spk = 0;
        for (int i = 0; i < N_IN; i++) m_tmr[i] = 0;
        rst_n = 1'b1;
    endtask

    task automatic t_integrate();
        leak = 8'd1; threshold = 8'd200;
        in_spike = 4'b0001; cycle("R6");
        chk("R6", "pot after 2-1", 32'(membrane), 1);
        in_spike = 4'b0011; cycle("R6");
        chk("R6", "pot after 1+4-1", 32'(membrane), 4);
        idle(5, "R6");
        chk("R6", "floor at zero", 32'(membrane), 0);
    endtask

    task automatic t_fire();
        leak = '0; threshold = 8'd3; learn_ctl = 2'b00; refr_len = '0;
        in_spike = 4'b0011; cycle("R7");
        chk("R7", "spike on reach", 32'(out_spike), 1);
        chk("R7", "pot reset", 32'(membrane), 0);
        idle(1, "R7");
        chk("R7", "spike one cycle", 32'(out_spike), 0);
    endtask

    task automatic t_refractory();
        refr_len = 4'd2; threshold = 8'd3;
        in_spike = 4'b0011; cycle("R8");
        threshold = 8'd20;
        in_spike = 4'b1111; cycle("R8");
        chk("R8", "ignored 1", 32'(membrane), 0);
        cycle("R8");
        chk("R8", "ignored 2", 32'(membrane), 0);
        chk("R8", "no spike", 32'(out_spike), 0);
        cycle("R8");
        chk("R8", "resumes", 32'(membrane), 8);
        leak = 8'd255; refr_len = '0; idle(1, "R8");
        leak = '0; idle(5, "R2");
    endtask

    task automatic t_hold_and_depress();
        learn_ctl = 2'b11; ltp_en = '1; ltd_en = '1; threshold = 8'd200;
        in_spike = 4'b0001; cycle("R3");
        chk("R3", "no change without fire", 32'(weights), 32'hFF);
        leak = 8'd255; idle(1, "R3");
        leak = '0; idle(5, "R2");
        learn_ctl = 2'b10; ltd_en = 8'b1111_0011; threshold = 8'd2;
        in_spike = 4'b0001; cycle("R5");
        chk("R5", "gated clear", 32'(weights), 32'h0F);
        idle(5, "R2");
    endtask

    task automatic t_potentiate();
        learn_ctl = 2'b01; ltp_en = 8'b1101_0000; ltd_en = '1;
        win_len = 4'd3; threshold = 8'd2; leak = '0;
        in_spike = 4'b1000; cycle("R2");
        in_spike = 4'b0100; cycle("R2");
        idle(2, "R2");
        in_spike = 4'b0001; cycle("R4");
        chk("R4", "set at window edge only", 32'(weights), 32'h1F);
        chk("R2", "fire seen", 32'(out_spike), 1);
        threshold = 8'd200;
        in_spike = 4'b0100; cycle("R9");
        chk("R9", "new weight integrates", 32'(membrane), 1);
        idle(3, "R9");
    endtask

    initial begin
        t_reset();
        t_integrate();
        t_fire();
        t_refractory();
        t_hold_and_depress();
        t_potentiate();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule